// File: doc/BRIEF.md
# Dual Digital Potentiometer Wiper Register Controller

This block keeps the wiper settings of two 64-position digital potentiometers. Both channels are driven from one host command port. Each channel has a volatile 6-bit wiper counter and a bank of four stored registers that stand in for non-volatile memory. A host command can do any of the following:
- write the wiper directly;
- read or write any stored register;
- copy a stored register into the wiper;
- copy the wiper into a stored register;
- move the wiper one position up or down;
- read the wiper back.

Each wiper counter is decoded into a 64-bit one-hot tap select, which drives the switch array of its resistor string. Any command that changes a stored register models a slow non-volatile write. During that write the command port stays not-ready for a fixed, parameterised number of cycles.

There are two reset inputs. The power-on reset clears the stored registers to a default value and sets both wipers to that same value. The soft reset reloads each wiper from that channel's register 0 and leaves every stored register as it was.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: While and after power-on reset (`porRstN` low), every stored register holds `DEFAULT_VAL`, both wipers hold `DEFAULT_VAL`, and `cmdReady` is high once reset is released.
- R2: For each channel c, `tapSel[c*64 +: 64]` has exactly one bit set, at index equal to that channel's wiper value.
- R3: An accepted command with opcode 0 (`cmdValid` and `cmdReady` both high at a rising edge) loads `cmdData` into the wiper of channel `cmdCh`; the tap select shows the new value after that edge.
- R4: Opcode 2 writes `cmdData` into stored register `cmdSel` of channel `cmdCh`. Opcode 1 reads that register: `rdValid` is high for the one cycle after acceptance, and `rdData` carries the value.
- R5: Opcode 3 copies stored register `cmdSel` of channel `cmdCh` into that channel's wiper in one step.
- R6: Opcode 4 copies the wiper of channel `cmdCh` into stored register `cmdSel` of that channel.
- R7: Opcode 5 raises the wiper by one and opcode 6 lowers it by one. The wiper stays at 63 on an up-step and at 0 on a down-step. Neither opcode changes any stored register.
- R8: After an opcode 2 or 4 is accepted, `cmdReady` is low for exactly `BUSY_CYCLES` cycles. A `cmdValid` presented while `cmdReady` is low has no effect.
- R9: While `softRstN` is low at a rising edge, each wiper loads its channel's register 0, the stored registers keep their values, and `cmdReady` is low.
- R10: A command acts only on the channel that `cmdCh` selects; the other channel's wiper and registers do not change.
- R11: Opcode 7 reads the wiper of channel `cmdCh`, with the same `rdValid` timing as opcode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| softRstN | input | 1 | Wiper reload request, synchronous, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be accepted |
| cmdOp | input | 3 | Opcode 0..7 |
| cmdCh | input | 1 | Channel select |
| cmdSel | input | 2 | Stored register select |
| cmdData | input | 6 | Write data |
| rdValid | output | 1 | Read result valid |
| rdData | output | 6 | Read result |
| tapSel | output | 128 | One-hot tap selects, channel 0 in the low 64 bits |

## Verification
Direct writes go to values in the middle of the range and to both ends. These show whether the tap decode lines up with the wiper value and whether each channel is kept apart from the other. Step sequences run both up and down, and they are pushed past 63 and below 0, so a wrapping counter can be told apart from a saturating one. Register writes, save and load transfers, and a soft reset are then combined in one sequence. This shows whether the wiper really reloads from register 0, and whether the stored values survive the soft reset. A command held on the port during a busy window, while `cmdReady` is low, must leave no trace afterwards.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int TAPS   = 64;
  localparam int WBITS  = $clog2(TAPS);
  localparam int NCH    = 2;
  localparam int CHBITS = $clog2(NCH);
  localparam int NREG   = 4;
  localparam int RBITS  = $clog2(NREG);

  typedef enum logic [2:0] {
    OP_WIPER_WRITE = 3'd0,
    OP_REG_READ    = 3'd1,
    OP_REG_WRITE   = 3'd2,
    OP_LOAD_REG    = 3'd3,
    OP_SAVE_WIPER  = 3'd4,
    OP_STEP_UP     = 3'd5,
    OP_STEP_DOWN   = 3'd6,
    OP_WIPER_READ  = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    WSRC_HOST = 2'd0,
    WSRC_REG  = 2'd1,
    WSRC_UP   = 2'd2,
    WSRC_DOWN = 2'd3
  } wiper_src_e;

  typedef struct packed {
    logic              loadWiper;
    wiper_src_e        wiperSrc;
    logic              writeReg;
    logic              regFromWiper;
    logic              readReg;
    logic              readWiper;
    logic [CHBITS-1:0] ch;
    logic [RBITS-1:0]  sel;
    logic [WBITS-1:0]  data;
  } strobe_t;
endpackage

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [CHBITS-1:0] cmdCh,
  input  logic [RBITS-1:0]  cmdSel,
  input  logic [WBITS-1:0]  cmdData,
  output strobe_t           stb,
  output logic              rdValid
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busyCnt;
  logic          accept;
  logic          isStore;
  logic          isRead;
  opcode_e       op;

  assign op       = opcode_e'(cmdOp);
  assign cmdReady = (busyCnt == '0) && softRstN;
  assign accept   = cmdValid && cmdReady;
  assign isStore  = (op == OP_REG_WRITE) || (op == OP_SAVE_WIPER);
  assign isRead   = (op == OP_REG_READ) || (op == OP_WIPER_READ);

  always_comb begin
    stb      = '0;
    stb.ch   = cmdCh;
    stb.sel  = cmdSel;
    stb.data = cmdData;
    if (accept) begin
      unique case (op)
        OP_WIPER_WRITE: begin stb.loadWiper = 1'b1; stb.wiperSrc = WSRC_HOST; end
        OP_LOAD_REG:    begin stb.loadWiper = 1'b1; stb.wiperSrc = WSRC_REG;  end
        OP_STEP_UP:     begin stb.loadWiper = 1'b1; stb.wiperSrc = WSRC_UP;   end
        OP_STEP_DOWN:   begin stb.loadWiper = 1'b1; stb.wiperSrc = WSRC_DOWN; end
        OP_REG_WRITE:   stb.writeReg = 1'b1;
        OP_SAVE_WIPER:  begin stb.writeReg = 1'b1; stb.regFromWiper = 1'b1; end
        OP_REG_READ:    stb.readReg = 1'b1;
        OP_WIPER_READ:  stb.readWiper = 1'b1;
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      busyCnt <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= accept && isRead;
      if (accept && isStore)      busyCnt <= CW'(BUSY_CYCLES);
      else if (busyCnt != '0)     busyCnt <= busyCnt - 1'b1;
    end
  end

  AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!porRstN)
    (accept && isStore) |=> !cmdReady); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!porRstN)
    (accept && isRead) |=> rdValid); // R4
  AST_NO_READ_PULSE: assert property (@(posedge clk) disable iff (!porRstN)
    !(accept && isRead) |=> !rdValid); // R11
  AST_SOFT_BLOCKS: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |-> !cmdReady); // R9
endmodule

// File: rtl/dpot_datapath.sv
module dpot_datapath
  import dpot_pkg::*;
#(
  parameter logic [WBITS-1:0] DEFAULT_VAL = '0
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                softRstN,
  input  strobe_t             stb,
  output logic [WBITS-1:0]    rdData,
  output logic [NCH*TAPS-1:0] tapSel
);
  localparam logic [WBITS-1:0] MAX_TAP = WBITS'(TAPS - 1);

  logic [NCH-1:0][WBITS-1:0]            wiper;
  logic [NCH-1:0][NREG-1:0][WBITS-1:0]  dreg;
  logic [WBITS-1:0]                     nextWiper;
  logic [WBITS-1:0]                     curWiper;

  assign curWiper = wiper[stb.ch];

  always_comb begin
    unique case (stb.wiperSrc)
      WSRC_HOST: nextWiper = stb.data;
      WSRC_REG:  nextWiper = dreg[stb.ch][stb.sel];
      WSRC_UP:   nextWiper = (curWiper == MAX_TAP) ? curWiper : curWiper + 1'b1;
      default:   nextWiper = (curWiper == '0) ? curWiper : curWiper - 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      wiper <= {NCH{DEFAULT_VAL}};
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (!softRstN)
          wiper[c] <= dreg[c][0];
        else if (stb.loadWiper && (stb.ch == CHBITS'(c)))
          wiper[c] <= nextWiper;
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      dreg <= {(NCH*NREG){DEFAULT_VAL}};
    end else if (stb.writeReg) begin
      dreg[stb.ch][stb.sel] <= stb.regFromWiper ? curWiper : stb.data;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            rdData <= '0;
    else if (stb.readReg)    rdData <= dreg[stb.ch][stb.sel];
    else if (stb.readWiper)  rdData <= curWiper;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_tap
    assign tapSel[c*TAPS +: TAPS] = TAPS'(1) << wiper[c];

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!porRstN)
      $countones(tapSel[c*TAPS +: TAPS]) == 1); // R2
  end

  AST_STEP_KEEPS_REGS: assert property (@(posedge clk) disable iff (!porRstN)
    (stb.loadWiper && (stb.wiperSrc == WSRC_UP || stb.wiperSrc == WSRC_DOWN))
    |=> $stable(dreg)); // R7
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!porRstN)
    (softRstN && stb.loadWiper && stb.wiperSrc == WSRC_UP && curWiper == MAX_TAP)
    |=> $stable(wiper)); // R7
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!porRstN)
    (softRstN && stb.loadWiper && stb.wiperSrc == WSRC_DOWN && curWiper == '0)
    |=> $stable(wiper)); // R7
  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |=> (wiper[0] == $past(dreg[0][0])) && (wiper[1] == $past(dreg[1][0]))); // R9
  AST_SOFT_KEEPS_REGS: assert property (@(posedge clk) disable iff (!porRstN)
    !softRstN |=> $stable(dreg)); // R9
endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
  import dpot_pkg::*;
#(
  parameter int                BUSY_CYCLES = 500000,
  parameter logic [WBITS-1:0]  DEFAULT_VAL = '0
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                softRstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [2:0]          cmdOp,
  input  logic [CHBITS-1:0]   cmdCh,
  input  logic [RBITS-1:0]    cmdSel,
  input  logic [WBITS-1:0]    cmdData,
  output logic                rdValid,
  output logic [WBITS-1:0]    rdData,
  output logic [NCH*TAPS-1:0] tapSel
);
  strobe_t stb;

  dpot_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdCh(cmdCh), .cmdSel(cmdSel), .cmdData(cmdData),
    .stb(stb), .rdValid(rdValid)
  );

  dpot_datapath #(.DEFAULT_VAL(DEFAULT_VAL)) u_dp (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN),
    .stb(stb), .rdData(rdData), .tapSel(tapSel)
  );
endmodule

// File: tb/sim_dpot_wiper_ctrl.sv
module sim_dpot_wiper_ctrl;
  localparam int BUSY = 12;
  localparam logic [5:0] DEF = 6'd9;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic softRstN = 1'b1;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = '0;
  logic cmdCh = 1'b0;
  logic [1:0] cmdSel = '0;
  logic [5:0] cmdData = '0;
  logic rdValid;
  logic [5:0] rdData;
  logic [127:0] tapSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int expW [2];
  int expR [2][4];
  int expQ [$];
  string tagQ [$];

  always #10 clk = ~clk;

  dpot_wiper_ctrl #(.BUSY_CYCLES(BUSY), .DEFAULT_VAL(DEF)) u0 (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdCh(cmdCh), .cmdSel(cmdSel),
    .cmdData(cmdData), .rdValid(rdValid), .rdData(rdData), .tapSel(tapSel)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected read actual=%0d expected=none", rdData);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (int'(rdData) != e) begin
          errors++;
          $display("FAIL %s read actual=%0d expected=%0d", t, rdData, e);
        end
      end
    end
  end

  task automatic send(input int op, input int ch, input int sel, input int data);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdCh = 1'(ch); cmdSel = 2'(sel); cmdData = 6'(data);
    @(posedge clk);
    case (op)
      0: expW[ch] = data;
      2: expR[ch][sel] = data;
      3: expW[ch] = expR[ch][sel];
      4: expR[ch][sel] = expW[ch];
      5: if (expW[ch] < 63) expW[ch]++;
      6: if (expW[ch] > 0) expW[ch]--;
      default: ;
    endcase
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readReg(input int ch, input int sel, input string tag);
    expQ.push_back(expR[ch][sel]); tagQ.push_back(tag);
    send(1, ch, sel, 0);
  endtask

  task automatic readWiper(input int ch, input string tag);
    expQ.push_back(expW[ch]); tagQ.push_back(tag);
    send(7, ch, 0, 0);
  endtask

  task automatic checkTaps(input string tag);
    check(tag, longint'(tapSel[63:0] == (64'd1 << expW[0])), 1);
    check(tag, longint'(tapSel[127:64] == (64'd1 << expW[1])), 1);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      expW[c] = DEF;
      for (int r = 0; r < 4; r++) expR[c][r] = DEF;
    end
    repeat (3) @(negedge clk);
    checkTaps("R1 reset taps");
    porRstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", cmdReady, 1);
    readReg(0, 0, "R1 reg default");
    readReg(1, 3, "R1 reg default");

    // R3 direct writes, both ends, channel isolation R10
    send(0, 0, 0, 37); checkTaps("R3 write ch0 37");
    send(0, 1, 0, 0);  checkTaps("R3 write ch1 0 / R10");
    send(0, 0, 0, 63); checkTaps("R2 tap 63");
    readWiper(0, "R11 wiper read");
    readWiper(1, "R11 wiper read");

    // R7 saturation
    send(5, 0, 0, 0); checkTaps("R7 up at 63");
    send(6, 1, 0, 0); checkTaps("R7 down at 0");
    send(6, 0, 0, 0); checkTaps("R7 down");
    send(5, 1, 0, 0); send(5, 1, 0, 0); checkTaps("R7 up twice");
    readReg(0, 0, "R7 regs untouched");
    readReg(1, 0, "R7 regs untouched");

    // R4 / R8 register write and busy length
    send(2, 0, 1, 33);
    begin
      int n = 0;
      while (!cmdReady) begin n++; @(negedge clk); end
      check("R8 busy length", n, BUSY);
    end
    readReg(0, 1, "R4 reg write/read");
    send(2, 1, 0, 50);
    send(2, 1, 2, 21);
    readReg(1, 0, "R4 ch1 r0");
    readReg(0, 0, "R10 ch0 r0 untouched");

    // R5 load and R6 save
    send(3, 0, 1, 0); checkTaps("R5 load R1 into ch0");
    send(0, 1, 0, 44);
    send(4, 1, 3, 0);
    readReg(1, 3, "R6 save wiper");

    // R8 ignored command during busy
    send(4, 0, 2, 0);
    check("R8 not ready", cmdReady, 0);
    cmdValid = 1'b1; cmdOp = 3'd0; cmdCh = 1'b1; cmdData = 6'd7;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdReady) @(negedge clk);
    checkTaps("R8 ignored while busy");
    readReg(0, 2, "R6 save ch0");

    // R9 soft reset
    send(0, 0, 0, 5); send(0, 1, 0, 60);
    softRstN = 1'b0;
    @(negedge clk);
    check("R9 not ready in soft reset", cmdReady, 0);
    softRstN = 1'b1;
    expW[0] = expR[0][0]; expW[1] = expR[1][0];
    checkTaps("R9 soft reload");
    readReg(0, 1, "R9 regs kept");
    readReg(1, 3, "R9 regs kept");

    repeat (3) @(negedge clk);
    check("R4 all reads returned", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule